// File: doc/BRIEF.md
# Single-Precision to Brain-Float Converter

This block converts between 32-bit IEEE-754 single-precision bit patterns and the 16-bit brain-float format. That format keeps the sign and the 8-bit exponent of single precision and keeps a 7-bit fraction. Each item on the input stream carries a direction bit. A narrowing item turns a 32-bit word into a 16-bit result. It rounds to nearest with ties to even, and it turns every NaN into a quiet NaN. A widening item takes the low 16 bits of the input word and pads them with sixteen zero bits below to form a 32-bit result. Words are raw bit patterns on both sides.

Both sides of the block use a valid/ready stream. An item moves across an edge on a rising clock edge at which valid and ready are both high. With `REG_OUT=1` the result sits in a single output register. While that register holds an item that is not yet taken, `in_ready` stays low, and `out_word` holds still until `out_ready` is seen. With `REG_OUT=0` the block is purely combinational. In that mode `in_ready` follows `out_ready`, `out_valid` follows `in_valid`, and the result appears in the same cycle.

Top module: `bf_convert`

## Requirements
- R1: A narrowing item whose input is not a NaN yields the upper 16 bits of the input after rounding to nearest with ties to even on the 16 dropped low bits. The result keeps the input sign bit (bit 31 of the input becomes bit 15 of the result).
- R2: When the dropped low 16 bits are exactly 0x8000, the result is the truncated value if its bit 0 is 0. Otherwise it is the truncated value plus one (0x3F808000 gives 0x3F80; 0x3F818000 gives 0x3F82).
- R3: A narrowing input with exponent field (bits 30:23) all ones and a nonzero fraction (bits 22:0) yields sign, exponent 0xFF, fraction bit 6 forced to 1, and fraction bits 5:0 taken from input bits 21:16. For example, 0x7F800001 gives 0x7FC0 and 0xFF810000 gives 0xFFC1.
- R4: A rounding carry out of the fraction increments the exponent (0x3FFFFFFF gives 0x4000). The largest finite magnitudes round to infinity with their sign (0x7F7FFFFF gives 0x7F80; 0xFF7FFFFF gives 0xFF80). A non-NaN input never yields a NaN.
- R5: Infinities and signed zeros narrow unchanged: 0x7F800000 gives 0x7F80, 0xFF800000 gives 0xFF80, 0x80000000 gives 0x8000.
- R6: A widening item (`in_dir`=1) yields `{in_word[15:0], 16'h0000}`. `in_word[31:16]` is ignored.
- R7: A narrowing item (`in_dir`=0) places its 16-bit result in `out_word[15:0]`, with `out_word[31:16]` zero.
- R8: With `REG_OUT=1`, an accepted item appears on `out_valid`/`out_word` one clock later. While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_word` is unchanged. Reset clears `out_valid`.
- R9: With `REG_OUT=0`, `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and `out_word` is the result for the current input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Block can take an input item |
| in_dir | input | 1 | 0 narrows, 1 widens |
| in_word | input | 32 | Input bit pattern (widening uses bits 15:0) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_word | output | 32 | Result bit pattern |

## Verification
With the output register in place, each result is due on the clock edge after the edge that accepts its input. The bench drives each new input at a falling edge and compares the output at the next falling edge. This lets a full sweep run at one item per cycle, with every comparison one edge behind its stimulus. During the back-pressure sequence, the held result is checked again one and two cycles after capture, and the follower is checked on the cycle after `out_ready` rises. On the combinational instance, outputs are compared in the same half cycle in which the inputs were set.

// File: rtl/bf_conv_pkg.sv
package bf_conv_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int EXPO_W = 8;

  typedef enum logic {
    DIR_NARROW = 1'b0,
    DIR_WIDEN  = 1'b1
  } dir_e;
endpackage

// File: rtl/bf_narrow.sv
module bf_narrow #(
  parameter int WIDE_W   = bf_conv_pkg::WORD_W,
  parameter int NARROW_W = bf_conv_pkg::HALF_W,
  parameter int EXP_W    = bf_conv_pkg::EXPO_W
) (
  input  logic [WIDE_W-1:0]   wide_i,
  output logic [NARROW_W-1:0] narrow_o
);
  localparam int DROP   = WIDE_W - NARROW_W;
  localparam int MAN_W  = WIDE_W - 1 - EXP_W;
  localparam int NMAN_W = NARROW_W - 1 - EXP_W;

  logic              sgn;
  logic [EXP_W-1:0]  expo;
  logic [MAN_W-1:0]  man;
  logic              is_nan;
  logic [WIDE_W-1:0] round_add;
  logic [WIDE_W-1:0] summed;
  logic [NARROW_W-1:0] rounded;
  logic [NARROW_W-1:0] quiet;

  assign sgn  = wide_i[WIDE_W-1];
  assign expo = wide_i[WIDE_W-2 -: EXP_W];
  assign man  = wide_i[MAN_W-1:0];
  assign is_nan = (&expo) && (|man);

  // half-ulp minus one, plus the kept LSB: ties go to even
  assign round_add = WIDE_W'({(DROP-1){1'b1}}) + WIDE_W'(wide_i[DROP]);
  assign summed    = wide_i + round_add;
  assign rounded   = summed[WIDE_W-1:DROP];
  assign quiet     = {sgn, {EXP_W{1'b1}}, 1'b1, man[MAN_W-2 -: NMAN_W-1]};

  // NaN path wins over rounding
  assign narrow_o = is_nan ? quiet : rounded;

  always_comb begin
    if (is_nan) begin
      p_nan_quiet_r3: assert ((&narrow_o[NARROW_W-2 -: EXP_W]) && narrow_o[NMAN_W-1]
                              && narrow_o[NARROW_W-1] == sgn)
        else $error("NaN input did not leave as quiet NaN");
    end else begin
      p_num_not_nan_r4: assert (!((&narrow_o[NARROW_W-2 -: EXP_W]) && (|narrow_o[NMAN_W-1:0])))
        else $error("number input produced a NaN");
      p_sign_kept_r1: assert (narrow_o[NARROW_W-1] == sgn)
        else $error("sign changed by rounding");
    end
    if (man == '0 && (expo == '0 || (&expo))) begin
      p_special_pass_r5: assert (narrow_o == wide_i[WIDE_W-1 -: NARROW_W])
        else $error("zero or infinity altered");
    end
  end
endmodule

// File: rtl/bf_widen.sv
module bf_widen #(
  parameter int WIDE_W   = bf_conv_pkg::WORD_W,
  parameter int NARROW_W = bf_conv_pkg::HALF_W
) (
  input  logic [NARROW_W-1:0] narrow_i,
  output logic [WIDE_W-1:0]   wide_o
);
  localparam int PAD = WIDE_W - NARROW_W;
  assign wide_o = {narrow_i, {PAD{1'b0}}};
endmodule

// File: rtl/bf_out_stage.sv
module bf_out_stage #(
  parameter int W       = bf_conv_pkg::WORD_W,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic         vld_q;
      logic [W-1:0] dat_q;

      assign in_ready  = !vld_q || out_ready;
      assign out_valid = vld_q;
      assign out_data  = dat_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          dat_q <= '0;
        end else if (in_ready) begin
          vld_q <= in_valid;
          if (in_valid) dat_q <= in_data;
        end
      end

      p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data))
        else $error("held result changed under back-pressure");
      p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready)
        else $error("input accepted while output blocked");
      p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid && out_data == $past(in_data))
        else $error("accepted item not presented next cycle");
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/bf_convert.sv
module bf_convert #(
  parameter int WIDE_W   = bf_conv_pkg::WORD_W,
  parameter int NARROW_W = bf_conv_pkg::HALF_W,
  parameter int EXP_W    = bf_conv_pkg::EXPO_W,
  parameter bit REG_OUT  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_dir,
  input  logic [WIDE_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WIDE_W-1:0] out_word
);
  localparam int PAD = WIDE_W - NARROW_W;

  logic [NARROW_W-1:0] narrow_res;
  logic [WIDE_W-1:0]   widen_res;
  logic [WIDE_W-1:0]   result;

  bf_narrow #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .EXP_W(EXP_W)) u_narrow (
    .wide_i  (in_word),
    .narrow_o(narrow_res)
  );

  bf_widen #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_widen (
    .narrow_i(in_word[NARROW_W-1:0]),
    .wide_o  (widen_res)
  );

  assign result = (in_dir == bf_conv_pkg::DIR_WIDEN) ? widen_res
                                                     : {{PAD{1'b0}}, narrow_res};

  bf_out_stage #(.W(WIDE_W), .REG_OUT(REG_OUT)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (result),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_word)
  );

  generate
    if (REG_OUT) begin : g_chk_reg
      p_widen_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_dir |=>
          out_word == {$past(in_word[NARROW_W-1:0]), {PAD{1'b0}}})
        else $error("widened word not zero padded");
      p_narrow_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_dir |=> out_word[WIDE_W-1:NARROW_W] == '0)
        else $error("narrow result upper half not zero");
      p_reset_idle_r8: assert property (@(posedge clk)
        !rst_n |=> !out_valid)
        else $error("output valid after reset");
    end else begin : g_chk_comb
      always_comb begin
        p_comb_pass_r9: assert (out_valid == in_valid && in_ready == out_ready)
          else $error("combinational handshake mismatch");
      end
    end
  endgenerate
endmodule

// File: tb/bf_convert_test.sv
module bf_convert_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_dir = 1'b0;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_word;

  logic        c_in_valid = 1'b0;
  logic        c_in_ready;
  logic        c_in_dir = 1'b0;
  logic [31:0] c_in_word = '0;
  logic        c_out_valid;
  logic        c_out_ready = 1'b0;
  logic [31:0] c_out_word;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  bf_convert #(.REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dir(in_dir), .in_word(in_word), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word)
  );

  bf_convert #(.REG_OUT(1'b0)) uut_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(c_in_valid), .in_ready(c_in_ready),
    .in_dir(c_in_dir), .in_word(c_in_word), .out_valid(c_out_valid),
    .out_ready(c_out_ready), .out_word(c_out_word)
  );

  function automatic logic [31:0] model(input logic dir, input logic [31:0] w);
    logic [15:0] hi, lo;
    hi = w[31:16];
    lo = w[15:0];
    if (dir) return {w[15:0], 16'h0000};
    if (w[30:23] == 8'hFF && w[22:0] != 0) return {16'h0, w[31], 8'hFF, 1'b1, w[21:16]};
    if (lo > 16'h8000 || (lo == 16'h8000 && hi[0])) hi = hi + 16'd1;
    return {16'h0, hi};
  endfunction

  function automatic string tag_of(input logic dir, input logic [31:0] w);
    if (dir) return "R6";
    if (w[30:23] == 8'hFF && w[22:0] != 0) return "R3";
    if (w[15:0] == 16'h8000) return "R2";
    return "R1/R7";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  task automatic one(input logic dir, input logic [31:0] w, input logic [31:0] exp, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_dir = dir; in_word = w;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {31'h0, out_valid}, 32'h1);
    check(req, out_word, exp);
  endtask

  initial begin
    logic [31:0] exp_a, exp_b, prev_exp;
    logic [15:0] lows [5];
    string prev_tag;
    bit have_prev;
    lows[0] = 16'h0000; lows[1] = 16'h7FFF; lows[2] = 16'h8000;
    lows[3] = 16'h8001; lows[4] = 16'hFFFF;

    repeat (3) @(negedge clk);
    check("R8 reset out_valid", {31'h0, out_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corner cases
    one(1'b0, 32'h3F808000, 32'h00003F80, "R2 tie even");
    one(1'b0, 32'h3F818000, 32'h00003F82, "R2 tie odd");
    one(1'b0, 32'h7F800001, 32'h00007FC0, "R3 snan");
    one(1'b0, 32'hFF810000, 32'h0000FFC1, "R3 neg nan payload");
    one(1'b0, 32'h7FC00000, 32'h00007FC0, "R3 qnan");
    one(1'b0, 32'h7FFFFFFF, 32'h00007FFF, "R3 nan no wrap");
    one(1'b0, 32'h3FFFFFFF, 32'h00004000, "R4 carry into exponent");
    one(1'b0, 32'h7F7FFFFF, 32'h00007F80, "R4 max to +inf");
    one(1'b0, 32'hFF7FFFFF, 32'h0000FF80, "R4 max to -inf");
    one(1'b0, 32'h7F800000, 32'h00007F80, "R5 +inf");
    one(1'b0, 32'hFF800000, 32'h0000FF80, "R5 -inf");
    one(1'b0, 32'h80000000, 32'h00008000, "R5 -zero");
    one(1'b0, 32'h00000000, 32'h00000000, "R5 +zero");
    one(1'b1, 32'hABCD1234, 32'h12340000, "R6 upper ignored");
    one(1'b0, 32'hC0490FDB, 32'h0000C049, "R1 round down");
    one(1'b0, 32'h3F80C000, 32'h00003F81, "R1 round up");

    // narrowing sweep: every upper half, low half cycling through boundary values
    have_prev = 1'b0;
    for (int i = 0; i < 65536; i++) begin
      logic [31:0] w;
      w = {i[15:0], lows[i % 5]};
      @(negedge clk);
      if (have_prev) check(prev_tag, out_word, prev_exp);
      in_valid = 1'b1; in_dir = 1'b0; in_word = w;
      prev_exp = model(1'b0, w); prev_tag = tag_of(1'b0, w); have_prev = 1'b1;
    end
    // widening sweep: every half word, upper input half filled with noise
    for (int i = 0; i < 65536; i++) begin
      logic [31:0] w;
      w = {i[15:0] ^ 16'h5A5A, i[15:0]};
      @(negedge clk);
      check(prev_tag, out_word, prev_exp);
      in_valid = 1'b1; in_dir = 1'b1; in_word = w;
      prev_exp = model(1'b1, w); prev_tag = tag_of(1'b1, w);
    end
    @(negedge clk);
    check(prev_tag, out_word, prev_exp);
    in_valid = 1'b0;
    @(negedge clk);

    // back-pressure: R8
    exp_a = model(1'b0, 32'h40490FDB);
    exp_b = model(1'b1, 32'h0000BEEF);
    out_ready = 1'b0;
    in_valid = 1'b1; in_dir = 1'b0; in_word = 32'h40490FDB;
    @(negedge clk);
    check("R8 latency", out_word, exp_a);
    in_dir = 1'b1; in_word = 32'h0000BEEF;
    check("R8 stall in_ready", {31'h0, in_ready}, 32'h0);
    @(negedge clk);
    check("R8 hold word", out_word, exp_a);
    check("R8 hold valid", {31'h0, out_valid}, 32'h1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 next item", out_word, exp_b);
    @(negedge clk);
    check("R8 drained", {31'h0, out_valid}, 32'h0);

    // combinational variant: R9
    c_in_valid = 1'b1; c_out_ready = 1'b0; c_in_dir = 1'b0; c_in_word = 32'h3F818000;
    #1;
    check("R9 valid pass", {31'h0, c_out_valid}, 32'h1);
    check("R9 ready pass", {31'h0, c_in_ready}, 32'h0);
    check("R9 same cycle narrow", c_out_word, 32'h00003F82);
    c_out_ready = 1'b1; c_in_dir = 1'b1; c_in_word = 32'hFFFF00FF;
    #1;
    check("R9 ready pass high", {31'h0, c_in_ready}, 32'h1);
    check("R9 same cycle widen", c_out_word, 32'h00FF0000);
    c_in_valid = 1'b0;
    #1;
    check("R9 valid low", {31'h0, c_out_valid}, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule